// File: doc/BRIEF.md
# SPI master with per-select timing attributes

This block is an SPI master that sends and receives one frame per queued TX entry. Each entry names a chip-select index. That index drives the matching chip-select pin and also picks one of eight stored attribute sets for the frame. An attribute set fixes the frame length, the clock polarity and phase, the bit order, the SCK rate, and three chip-select delays. The three delays are: lead (CS active to the first SCK edge), trail (last SCK edge to CS inactive) and gap (CS inactive to the next CS active).

A host reaches the block through a small register bus. Writes take effect on the clock edge. Reads are combinational, and a read of the RX address pops that FIFO. The host writes attribute sets, pushes TX entries into a 4-deep FIFO, pops right-justified receive words from a 4-deep FIFO, and polls or takes an interrupt on an end-of-queue flag. Each chip-select pin has its own programmable idle level. All rates and delays are powers of two of the system clock, so one down-counter is enough for every interval.

Top module: `spi_attr_master`

## Requirements
- R1: After reset, sck, sout and irq are low, each cs_pin bit equals its idle bit (reset value 0), and STATUS (address 1) reads 0.
- R2: Attribute set k is written at address 8+k. Its bits [3:0] hold the frame length minus one, so frames are 4 to 16 bits long. Codes 0 to 2 give 4-bit frames.
- R3: Attribute bit 4 is the polarity and bit 5 is the phase. SCK rests at the polarity level. With phase 0, the first data bit is on sout before the first edge, sin is captured on edges 1, 3, 5 and so on, and sout changes on the even edges. With phase 1, sout changes on the odd edges and sin is captured on the even edges.
- R4: Attribute bit 6 set sends LSB first; clear sends MSB first. Received bits are placed by the same order, right-justified. Reading address 3 returns the oldest word and pops it. The read returns 0 when the FIFO is empty.
- R5: SCK half period, with br in attribute bits [11:8] and the double-rate flag in bit 7: 2^br clocks when the flag is set, 2^(br+1) clocks when it is clear.
- R6: Lead code is attribute bits [15:12], trail code [19:16], gap code [23:20]. Code n lasts 2^(n+1) clocks. CS is active from the cycle after the entry is taken, for lead + 2·L·half + trail cycles. It then stays inactive for gap cycles plus one idle cycle before a queued entry is taken.
- R7: A TX push writes address 2 with data in [15:0], the select index in [18:16] and the end-of-queue mark in [19]. CTRL (address 0) bits [15:8] are the per-pin idle levels. An active pin drives the opposite of its idle level, and at most one pin is active at a time.
- R8: CTRL bit 0 enables the master and bit 1 halts it. A new entry is taken only when the enable bit is 1 and halt is 0. A frame already under way always completes.
- R9: Writing CTRL with bit 2 set empties the TX FIFO, and with bit 3 set empties the RX FIFO. Both bits read back as 0.
- R10: STATUS[0] is set on the clock of a frame's final SCK edge. STATUS[2:0] are cleared by writing 1, and a set in the same cycle wins. STATUS[6:4] is the TX count and STATUS[10:8] is the RX count.
- R11: STATUS[1] is set on the clock where CS of a frame with an end-of-queue mark goes inactive. irq equals CTRL[4] AND STATUS[1].
- R12: A frame that completes while the RX FIFO is full is dropped, and STATUS[2] is set.
- R13: Both FIFOs hold 4 entries. A push to a full TX FIFO is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops RX at address 3) |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| irq | output | 1 | End-of-queue interrupt |
| sck | output | 1 | Serial clock |
| sout | output | 1 | Serial data out |
| sin | input | 1 | Serial data in |
| cs_pin | output | NCS | Chip-select pins |

## Verification
Each attribute set uses a different mix of the four clock modes, both bit orders, frame lengths of 4, 8, 12 and 16 (plus a clamped code), and unequal lead, trail, gap and half-period values. A wrong edge choice, a reversed bit order or an off-by-one count in any delay therefore shows up on a different pin or a different cycle. sin loops back from sout both straight and inverted, so a fixed-value capture cannot pass. Transfers are also queued back to back, held by halt or a cleared enable, flushed, and pushed past a full FIFO. These cases separate the start conditions, the drop-on-overflow rule and the end-of-queue flag timing from the ordinary frame path.

// File: rtl/spi_attr_master.sv
module spi_attr_master #(
  parameter int NCS   = 8,
  parameter int DEPTH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_wr,
  input  logic           bus_rd,
  input  logic [3:0]     bus_addr,
  input  logic [31:0]    bus_wdata,
  output logic [31:0]    bus_rdata,
  output logic           irq,
  output logic           sck,
  output logic           sout,
  input  logic           sin,
  output logic [NCS-1:0] cs_pin
);
  localparam int PW   = $clog2(DEPTH);
  localparam int CW   = PW + 1;
  localparam int SW   = $clog2(NCS);
  localparam int CNTW = 17;

  typedef enum logic [2:0] {S_IDLE, S_LEAD, S_SHIFT, S_TRAIL, S_GAP} st_t;

  logic           master_en, halt, eoq_ie;
  logic [NCS-1:0] cs_idle;
  logic [23:0]    attr [NCS];
  logic [19:0]    txq [DEPTH];
  logic [15:0]    rxq [DEPTH];
  logic [PW-1:0]  tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0]  tx_cnt, rx_cnt;
  logic           done_f, eoq_f, ovf_f;
  st_t            st;
  logic [CNTW-1:0] cnt;
  logic [4:0]     edges;
  logic [15:0]    cur_data, rx_word, rx_next;
  logic [2:0]     cur_cs;
  logic           cur_eoq;
  logic [23:0]    cur_attr;

  function automatic logic [CNTW-1:0] span(input logic [4:0] e);
    return (CNTW'(1) << e) - 1'b1;
  endfunction

  wire ctrl_wr  = bus_wr && bus_addr == 4'd0;
  wire stat_wr  = bus_wr && bus_addr == 4'd1;
  wire tx_push  = bus_wr && bus_addr == 4'd2 && tx_cnt != CW'(DEPTH);
  wire rx_pop   = bus_rd && bus_addr == 4'd3 && rx_cnt != '0;
  wire flush_tx = ctrl_wr && bus_wdata[2];
  wire flush_rx = ctrl_wr && bus_wdata[3];

  wire [19:0] head      = txq[tx_rp];
  wire [23:0] head_attr = attr[head[16 +: SW]];
  wire        start     = st == S_IDLE && tx_cnt != '0 && master_en && !halt;

  wire [3:0] len_m1 = (cur_attr[3:0] < 4'd3) ? 4'd3 : cur_attr[3:0];
  wire       cpol = cur_attr[4], cpha = cur_attr[5], lsb = cur_attr[6];
  wire [4:0] hexp = cur_attr[7] ? {1'b0, cur_attr[11:8]} : {1'b0, cur_attr[11:8]} + 5'd1;
  wire       tick = cnt == '0;
  wire [4:0] bsel = (cpha && edges != 5'd0) ? edges - 5'd1 : edges;
  wire [3:0] pos  = lsb ? bsel[4:1] : len_m1 - bsel[4:1];
  wire       sample    = st == S_SHIFT && tick && (edges[0] == cpha);
  wire       last_edge = st == S_SHIFT && tick && edges == {len_m1, 1'b1};
  wire       rx_full   = rx_cnt == CW'(DEPTH);
  wire       cs_active = st == S_LEAD || st == S_SHIFT || st == S_TRAIL;

  always_comb begin
    rx_next = rx_word;
    if (sample) rx_next[pos] = sin;
  end

  assign sck  = cpol ^ edges[0];
  assign sout = (st == S_LEAD || st == S_SHIFT) ? cur_data[pos] : 1'b0;
  assign irq  = eoq_ie & eoq_f;

  for (genvar k = 0; k < NCS; k++) begin : g_cs
    assign cs_pin[k] = cs_idle[k] ^ (cs_active && cur_cs == 3'(k));
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      master_en <= 1'b0; halt <= 1'b0; eoq_ie <= 1'b0; cs_idle <= '0;
      for (int k = 0; k < NCS; k++) attr[k] <= '0;
    end else if (bus_wr) begin
      if (ctrl_wr) begin
        master_en <= bus_wdata[0];
        halt      <= bus_wdata[1];
        eoq_ie    <= bus_wdata[4];
        cs_idle   <= bus_wdata[8 +: NCS];
      end
      for (int k = 0; k < NCS; k++)
        if (bus_addr == 4'(8 + k)) attr[k] <= bus_wdata[23:0];
    end

  always_ff @(posedge clk) begin
    if (tx_push) txq[tx_wp] <= bus_wdata[19:0];
    if (last_edge && !rx_full) rxq[rx_wp] <= rx_next;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (flush_tx) begin
        tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
      end else begin
        if (tx_push) tx_wp <= tx_wp + 1'b1;
        if (start)   tx_rp <= tx_rp + 1'b1;
        tx_cnt <= tx_cnt + CW'(tx_push) - CW'(start);
      end
      if (flush_rx) begin
        rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
      end else begin
        if (last_edge && !rx_full) rx_wp <= rx_wp + 1'b1;
        if (rx_pop) rx_rp <= rx_rp + 1'b1;
        rx_cnt <= rx_cnt + CW'(last_edge && !rx_full) - CW'(rx_pop);
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      done_f <= 1'b0; eoq_f <= 1'b0; ovf_f <= 1'b0;
    end else begin
      done_f <= last_edge | (done_f & ~(stat_wr & bus_wdata[0]));
      eoq_f  <= (st == S_TRAIL && tick && cur_eoq) | (eoq_f & ~(stat_wr & bus_wdata[1]));
      ovf_f  <= (last_edge && rx_full) | (ovf_f & ~(stat_wr & bus_wdata[2]));
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; edges <= '0; rx_word <= '0;
      cur_data <= '0; cur_cs <= '0; cur_eoq <= 1'b0; cur_attr <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          cur_data <= head[15:0];
          cur_cs   <= head[18:16];
          cur_eoq  <= head[19];
          cur_attr <= head_attr;
          cnt      <= span({1'b0, head_attr[15:12]} + 5'd1);
          edges    <= '0;
          rx_word  <= '0;
          st       <= S_LEAD;
        end
        S_LEAD: if (tick) begin
          st <= S_SHIFT; cnt <= span(hexp);
        end else cnt <= cnt - 1'b1;
        S_SHIFT: begin
          rx_word <= rx_next;
          if (tick) begin
            edges <= edges + 5'd1;
            if (last_edge) begin
              st <= S_TRAIL; cnt <= span({1'b0, cur_attr[19:16]} + 5'd1);
            end else cnt <= span(hexp);
          end else cnt <= cnt - 1'b1;
        end
        S_TRAIL: if (tick) begin
          st <= S_GAP; cnt <= span({1'b0, cur_attr[23:20]} + 5'd1);
        end else cnt <= cnt - 1'b1;
        default: if (tick) st <= S_IDLE; else cnt <= cnt - 1'b1;
      endcase
    end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      4'd0: begin
        bus_rdata[0] = master_en; bus_rdata[1] = halt; bus_rdata[4] = eoq_ie;
        bus_rdata[8 +: NCS] = cs_idle;
      end
      4'd1: begin
        bus_rdata[0] = done_f; bus_rdata[1] = eoq_f; bus_rdata[2] = ovf_f;
        bus_rdata[4 +: CW] = tx_cnt; bus_rdata[8 +: CW] = rx_cnt;
      end
      4'd3: bus_rdata[15:0] = (rx_cnt != '0) ? rxq[rx_rp] : 16'h0;
      default: if (bus_addr[3]) bus_rdata[23:0] = attr[bus_addr[SW-1:0]];
    endcase
  end

  // R7
  one_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cs_pin ^ cs_idle) <= 1);
  // R13
  tx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= CW'(DEPTH) && rx_cnt <= CW'(DEPTH));
  // R8
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && halt) |=> st == S_IDLE);
  // R6
  lead_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_LEAD |=> $stable(sck));
  // R12
  ovf_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last_edge && rx_full && !flush_rx && !rx_pop) |=> (ovf_f && rx_cnt == CW'(DEPTH)));
  // R10
  done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_edge |=> done_f);
endmodule

// File: tb/tb_spi_attr_master.sv
module tb_spi_attr_master;
  localparam int NCS = 8;
  localparam int DEPTH = 4;

  logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0, inv_sin = 1'b0;
  logic [3:0]  bus_addr = 4'd1;
  logic [31:0] bus_wdata = '0;
  wire  [31:0] bus_rdata;
  wire irq, sck, sout;
  wire [NCS-1:0] cs_pin;
  wire sin = sout ^ inv_sin;

  always #10 clk = ~clk;

  spi_attr_master #(.NCS(NCS), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .sck(sck), .sout(sout),
    .sin(sin), .cs_pin(cs_pin));

  int vectors = 0, errors = 0;
  bit finished = 0;

  // reference model state
  bit m_master, m_halt, m_eoqie, m_done, m_eoq, m_ovf, m_act;
  bit [7:0] m_idle;
  int m_attr [8];
  int txq[$];
  int rxq[$];
  int m_t, c_data, c_cs, c_eoq, c_L, c_H, c_A, c_B, c_G, c_cpol, c_cpha, c_lsb, last_cpol;

  task automatic latch(int ent);
    int a;
    c_data = ent & 'hFFFF; c_cs = (ent >> 16) & 7; c_eoq = (ent >> 19) & 1;
    a = m_attr[c_cs];
    c_L = ((a & 15) < 3) ? 4 : (a & 15) + 1;
    c_cpol = (a >> 4) & 1; c_cpha = (a >> 5) & 1; c_lsb = (a >> 6) & 1;
    c_H = ((a >> 7) & 1) ? (1 << ((a >> 8) & 15)) : (1 << (((a >> 8) & 15) + 1));
    c_A = 1 << (((a >> 12) & 15) + 1);
    c_B = 1 << (((a >> 16) & 15) + 1);
    c_G = 1 << (((a >> 20) & 15) + 1);
    last_cpol = c_cpol;
  endtask

  always @(posedge clk) begin : model
    int txn, rxn, se;
    bit hlt, mst;
    if (!rst_n) begin
      m_master = 0; m_halt = 0; m_eoqie = 0; m_done = 0; m_eoq = 0; m_ovf = 0;
      m_act = 0; m_idle = 0; last_cpol = 0; m_t = 0;
      for (int k = 0; k < 8; k++) m_attr[k] = 0;
      txq.delete(); rxq.delete();
    end else begin
      txn = txq.size(); rxn = rxq.size(); hlt = m_halt; mst = m_master;
      if (bus_wr && bus_addr == 4'd1) begin
        if (bus_wdata[0]) m_done = 0;
        if (bus_wdata[1]) m_eoq = 0;
        if (bus_wdata[2]) m_ovf = 0;
      end
      if (m_act) begin
        se = c_A + 2 * c_L * c_H;
        if (m_t == se - 1) begin
          if (rxn < DEPTH) rxq.push_back((c_data ^ (inv_sin ? 'hFFFF : 0)) & ((1 << c_L) - 1));
          else m_ovf = 1;
          m_done = 1;
        end
        if (m_t == se + c_B - 1 && c_eoq == 1) m_eoq = 1;
        if (m_t == se + c_B + c_G - 1) m_act = 0;
        else m_t++;
      end else if (txn > 0 && mst && !hlt) begin
        latch(txq.pop_front());
        m_act = 1; m_t = 0;
      end
      if (bus_rd && bus_addr == 4'd3 && rxn > 0) void'(rxq.pop_front());
      if (bus_wr) begin
        if (bus_addr == 4'd0) begin
          m_master = bus_wdata[0]; m_halt = bus_wdata[1]; m_eoqie = bus_wdata[4];
          m_idle = bus_wdata[15:8];
          if (bus_wdata[2]) txq.delete();
          if (bus_wdata[3]) rxq.delete();
        end else if (bus_addr == 4'd2) begin
          if (txn < DEPTH) txq.push_back(int'(bus_wdata[19:0]));
        end else if (bus_addr[3]) m_attr[bus_addr[2:0]] = int'(bus_wdata[23:0]);
      end
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit [7:0] e_cs;
    bit e_sck, e_sout;
    int e, se, idx, pos, st_exp, rx_exp;
    e_cs = m_idle; e_sck = last_cpol[0]; e_sout = 0;
    if (m_act) begin
      se = c_A + 2 * c_L * c_H;
      if (m_t < se + c_B) e_cs[c_cs] = ~e_cs[c_cs];
      e = (m_t < c_A) ? 0 : (m_t - c_A) / c_H;
      if (e > 2 * c_L) e = 2 * c_L;
      e_sck = c_cpol[0] ^ e[0];
      if (m_t < se) begin
        idx = c_cpha ? ((e == 0) ? 0 : (e - 1) / 2) : e / 2;
        pos = c_lsb ? idx : c_L - 1 - idx;
        e_sout = c_data[pos];
      end
    end
    chk(cs_pin == e_cs, "R7 cs_pin", int'(cs_pin), int'(e_cs));
    chk(sck == e_sck, "R5 sck", int'(sck), int'(e_sck));
    chk(sout == e_sout, "R4 sout", int'(sout), int'(e_sout));
    chk(irq == (m_eoqie & m_eoq), "R11 irq", int'(irq), int'(m_eoqie & m_eoq));
    if (bus_addr == 4'd1) begin
      st_exp = int'(m_done) | (int'(m_eoq) << 1) | (int'(m_ovf) << 2) |
               (txq.size() << 4) | (rxq.size() << 8);
      chk(bus_rdata == 32'(st_exp), "R10 status", int'(bus_rdata), st_exp);
    end else if (bus_addr == 4'd3) begin
      rx_exp = (rxq.size() > 0) ? rxq[0] : 0;
      chk(bus_rdata == 32'(rx_exp), "R4 rxdata", int'(bus_rdata), rx_exp);
    end
  endtask

  always begin
    @(negedge clk);
    #5;
    if (!finished) compare();
  end

  function automatic int mk(int lc, int cpol, int cpha, int lsb, int dbr, int br,
                            int lead, int trail, int gap);
    return lc | (cpol << 4) | (cpha << 5) | (lsb << 6) | (dbr << 7) | (br << 8) |
           (lead << 12) | (trail << 16) | (gap << 20);
  endfunction

  function automatic int ctl(int en, int hl, int ftx, int frx, int ie, int idle);
    return en | (hl << 1) | (ftx << 2) | (frx << 3) | (ie << 4) | (idle << 8);
  endfunction

  task automatic wr(int a, int d);
    @(negedge clk);
    bus_wr = 1; bus_addr = 4'(a); bus_wdata = 32'(d);
    @(negedge clk);
    bus_wr = 0; bus_addr = 4'd1; bus_wdata = '0;
  endtask

  task automatic push(int d, int cs, int eoq);
    wr(2, d | (cs << 16) | (eoq << 19));
  endtask

  task automatic pop();
    @(negedge clk);
    bus_rd = 1; bus_addr = 4'd3;
    @(negedge clk);
    bus_rd = 0; bus_addr = 4'd1;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain();
    while (m_act || txq.size() > 0) @(negedge clk);
    idle(3);
  endtask

  task automatic wrap_up();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    wrap_up();
  end

  initial begin
    idle(3);
    rst_n = 1;
    idle(4);                                   // R1 reset state compared each cycle
    wr(0, ctl(1, 0, 0, 0, 1, 'hA5));           // R7 idle levels, R11 irq enable
    wr(8,  mk(7, 0, 0, 0, 1, 0, 0, 0, 0));     // R2 8 bits, R3 mode 0, R5 fastest
    wr(9,  mk(15, 1, 1, 1, 0, 1, 1, 2, 0));    // R3 mode 3, R4 LSB first, R6 lead/trail
    wr(10, mk(3, 0, 1, 0, 1, 2, 0, 1, 2));     // R3 mode 1, R6 gap
    wr(13, mk(11, 1, 0, 1, 1, 1, 1, 0, 1));    // R3 mode 2, 12 bits
    wr(14, mk(1, 0, 0, 0, 1, 0, 0, 0, 0));     // R2 clamped length code
    push('hC3A5, 0, 0);
    push('h8421, 1, 0);
    push('h0009, 2, 0);
    push('h0ABC, 5, 1);                        // R11 end-of-queue mark
    drain();
    repeat (4) pop();                          // R4 right-justified readback
    pop();                                     // R4 empty read gives 0
    wr(1, 7);                                  // R10 write-1-to-clear
    inv_sin = 1;
    push('h005A, 6, 1);                        // R2 4-bit frame
    push('h1234, 1, 0);
    drain();
    pop(); pop();
    inv_sin = 0;
    wr(0, ctl(1, 1, 0, 0, 0, 'h3C));           // R8 halt, irq disabled
    for (int i = 0; i < 5; i++) push('h1111 * (i + 1), i % 3, 0);  // R13 fifth push ignored
    idle(30);
    wr(0, ctl(1, 0, 0, 0, 0, 'h3C));
    drain();
    push('hBEEF, 0, 1);                        // R12 RX full, frame dropped
    drain();
    wr(1, 7);
    wr(0, ctl(1, 1, 0, 0, 1, 'h00));
    push('h0F0F, 2, 0); push('hF0F0, 1, 0);
    wr(0, ctl(1, 1, 1, 1, 1, 'h00));           // R9 flush both FIFOs
    idle(5);
    wr(0, ctl(1, 0, 0, 0, 1, 'h00));
    idle(10);
    wr(0, ctl(0, 0, 0, 0, 1, 'hFF));           // R8 master disabled
    push('h0033, 5, 1);
    idle(20);
    wr(0, ctl(1, 0, 0, 0, 1, 'hFF));
    drain();                                   // R6 R11 timing of CS and flag
    pop();
    idle(5);
    wrap_up();
  end
endmodule